// File: doc/BRIEF.md
# Coprocessor Compare Flag Unit

This block compares two 64-bit operand words as one of four types: signed 32-bit integers, signed 64-bit integers, IEEE-754 single floats, or IEEE-754 double floats. It produces a 4-bit N/Z/C/V result in the coprocessor's native flag encoding. That encoding is the same for every operand type, and it differs from the main core's standard encoding. In particular, a greater-than result sets both N and V. A combinational translator maps the registered native flags to the standard encoding, so that ordinary condition tests keep working after a coprocessor compare. It also decodes one-hot less, equal, greater and unordered bits.

Operands enter through a valid/ready handshake. An operand pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is held in the output register on the next cycle with `out_valid` high. The result stays there until a rising edge where `out_ready` is also high. `in_ready` is high when the output register is empty or is being drained in the same cycle. This allows one compare per cycle when the consumer never stalls. While a result is stalled, `in_ready` is low and nothing new is accepted. Denormals are compared by their exact value, and no exceptions are raised.

Top module: `cmpu_flag_unit`

## Requirements
- R1: An equal compare gives native flags {N,Z,C,V} = 0100 (bit 3 is N, bit 0 is V) and raises `out_eq`.
- R2: A less-than compare gives native flags 1000 and raises `out_lt`.
- R3: A greater-than compare gives native flags 1001 and raises `out_gt`.
- R4: In the float kinds, a NaN in either operand gives native flags 0000 and raises `out_un`.
- R5: The standard flags are 0110 for equal, 1000 for less, 0010 for greater and 0011 for unordered.
- R6: Kind 0 compares bits [31:0] as signed integers, and bits [63:32] have no effect on the result.
- R7: Kind 1 compares all 64 bits as signed integers.
- R8: Kind 2 compares bits [63:32] as single floats. Bits [31:0] have no effect, and +0 equals -0.
- R9: Kind 3 compares the 64-bit doubles in IEEE order. Among negative values, the larger magnitude is less, and +0 equals -0.
- R10: A pair accepted on a rising edge shows its result, with `out_valid` high, from that edge until the edge that drains it.
- R11: While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low.
- R12: After reset, `out_valid` is low and `in_ready` is high.
- R13: Whenever `out_valid` is high, exactly one of `out_lt`, `out_eq`, `out_gt`, `out_un` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_kind | input | 2 | 0 int32, 1 int64, 2 single, 3 double |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_native | output | 4 | Native flags {N,Z,C,V} |
| out_std | output | 4 | Standard flags {N,Z,C,V} |
| out_lt | output | 1 | a < b |
| out_eq | output | 1 | a == b |
| out_gt | output | 1 | a > b |
| out_un | output | 1 | Unordered |

## Verification
A new operand pair can be accepted in the same cycle that the previous result is drained. The bench provokes this by keeping `in_valid` and `out_ready` high on consecutive edges. It then checks that each cycle shows the flags of the newer pair and not a mix with the older one. The bench also makes a stalled result meet a waiting new pair. It checks that the old flags hold and that `in_ready` stays low until the drain. It then checks that the waiting pair is accepted on the draining edge.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  typedef enum logic [1:0] {
    K_INT32 = 2'd0,
    K_INT64 = 2'd1,
    K_FP32  = 2'd2,
    K_FP64  = 2'd3
  } kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  // native encoding shared by integer and float compares
  function automatic nzcv_t native_of(rel_e r);
    nzcv_t f;
    case (r)
      REL_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b0, v: 1'b0};
      REL_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
      REL_GT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b1};
      default: f = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/cmpu_int_order.sv
module cmpu_int_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         eq
);
  // signed order: flip the sign bit, then compare as unsigned
  logic [W-1:0] ka, kb;
  always_comb begin
    ka = {~a[W-1], a[W-2:0]};
    kb = {~b[W-1], b[W-2:0]};
    lt = ka < kb;
    eq = a == b;
  end
endmodule

// File: rtl/cmpu_fp_order.sv
module cmpu_fp_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic                 lt,
  output logic                 eq,
  output logic                 un
);
  localparam int MAG_W = EXP_W + MAN_W;
  localparam int SB    = MAG_W;

  logic [MAG_W-1:0] mag_a, mag_b;
  logic nan_a, nan_b, zeros, mag_lt, mag_eq;

  always_comb begin
    mag_a  = a[MAG_W-1:0];
    mag_b  = b[MAG_W-1:0];
    nan_a  = (&a[MAG_W-1:MAN_W]) && (|a[MAN_W-1:0]);
    nan_b  = (&b[MAG_W-1:MAN_W]) && (|b[MAN_W-1:0]);
    zeros  = (mag_a == '0) && (mag_b == '0);
    mag_lt = mag_a < mag_b;
    mag_eq = mag_a == mag_b;
    un = nan_a || nan_b;
    eq = 1'b0;
    lt = 1'b0;
    if (!un) begin
      if (zeros) begin
        eq = 1'b1;
      end else if (a[SB] != b[SB]) begin
        lt = a[SB];
      end else begin
        eq = mag_eq;
        lt = a[SB] ? (!mag_lt && !mag_eq) : mag_lt;
      end
    end
  end
endmodule

// File: rtl/cmpu_xlate.sv
module cmpu_xlate
  import cmpu_pkg::*;
(
  input  nzcv_t native,
  output nzcv_t std_f,
  output logic  is_lt,
  output logic  is_eq,
  output logic  is_gt,
  output logic  is_un
);
  always_comb begin
    is_eq = native.z;
    is_lt = native.n && !native.v;
    is_gt = native.n && native.v;
    is_un = !(native.n || native.z || native.c || native.v);
    std_f.n = is_lt;
    std_f.z = is_eq;
    std_f.c = is_eq || is_gt || is_un;
    std_f.v = is_un;
  end
endmodule

// File: rtl/cmpu_flag_unit.sv
module cmpu_flag_unit
  import cmpu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NARROW_W = 32,
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_native,
  output logic [3:0]        out_std,
  output logic              out_lt,
  output logic              out_eq,
  output logic              out_gt,
  output logic              out_un
);
  localparam int SP_W = 1 + SP_EXP + SP_MAN;
  localparam int DP_W = 1 + DP_EXP + DP_MAN;
  localparam int NKIND = 4;

  logic [NKIND-1:0] k_lt, k_eq, k_un;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_int
      localparam int IW = (g == 0) ? NARROW_W : DATA_W;
      cmpu_int_order #(.W(IW)) u_int (
        .a (in_a[IW-1:0]),
        .b (in_b[IW-1:0]),
        .lt(k_lt[g]),
        .eq(k_eq[g])
      );
      assign k_un[g] = 1'b0;
    end
  endgenerate

  cmpu_fp_order #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
    .a (in_a[DATA_W-1 -: SP_W]),
    .b (in_b[DATA_W-1 -: SP_W]),
    .lt(k_lt[2]),
    .eq(k_eq[2]),
    .un(k_un[2])
  );

  cmpu_fp_order #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
    .a (in_a[DP_W-1:0]),
    .b (in_b[DP_W-1:0]),
    .lt(k_lt[3]),
    .eq(k_eq[3]),
    .un(k_un[3])
  );

  rel_e  rel_sel;
  nzcv_t nat_next, nat_q, std_w;
  logic  valid_q, accept;

  always_comb begin
    if (k_un[in_kind])      rel_sel = REL_UN;
    else if (k_eq[in_kind]) rel_sel = REL_EQ;
    else if (k_lt[in_kind]) rel_sel = REL_LT;
    else                    rel_sel = REL_GT;
    nat_next = native_of(rel_sel);
  end

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      nat_q   <= '0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        nat_q   <= nat_next;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  cmpu_xlate u_xl (
    .native(nat_q),
    .std_f (std_w),
    .is_lt (out_lt),
    .is_eq (out_eq),
    .is_gt (out_gt),
    .is_un (out_un)
  );

  assign out_valid  = valid_q;
  assign out_native = nat_q;
  assign out_std    = std_w;
endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_native,
  input logic [3:0] out_std,
  input logic       out_lt,
  input logic       out_eq,
  input logic       out_gt,
  input logic       out_un
);
  a_r10_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_native) && $stable(out_std));

  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r13_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_lt, out_eq, out_gt, out_un}) == 1);

  a_r5_greater_map: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_native == 4'b1001 |-> out_std == 4'b0010 && out_gt);

  a_r4_unordered_map: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_un |-> out_native == 4'b0000 && out_std == 4'b0011);
endmodule

bind cmpu_flag_unit cmpu_checker u_chk (.*);

// File: tb/test_cmpu_flag_unit.sv
module test_cmpu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_native, out_std;
  logic        out_lt, out_eq, out_gt, out_un;

  int checks = 0;
  int failures = 0;

  always #10ns clk = ~clk;

  cmpu_flag_unit i_cmpu_flag_unit (.*);

  // relation codes: 0 eq, 1 lt, 2 gt, 3 unordered
  function automatic int fp_rel(logic [63:0] x, logic [63:0] y, int w, int ew);
    logic [63:0] m, kx, ky, mag, sgn;
    logic [63:0] emask, mmask;
    int mw;
    mw    = w - 1 - ew;
    sgn   = 64'd1 << (w - 1);
    m     = (w == 64) ? '1 : ((64'd1 << w) - 1);
    mag   = m & ~sgn;
    mmask = (64'd1 << mw) - 1;
    emask = mag & ~mmask;
    if (((x & emask) == emask && (x & mmask) != 0) ||
        ((y & emask) == emask && (y & mmask) != 0)) return 3;
    if ((x & mag) == 0 && (y & mag) == 0) return 0;
    kx = (x & sgn) != 0 ? (~x & m) : (x | sgn);
    ky = (y & sgn) != 0 ? (~y & m) : (y | sgn);
    if (kx == ky) return 0;
    return (kx < ky) ? 1 : 2;
  endfunction

  function automatic int exp_rel(logic [1:0] k, logic [63:0] a, logic [63:0] b);
    case (k)
      2'd0: return ($signed(a[31:0]) == $signed(b[31:0])) ? 0 :
                   ($signed(a[31:0]) <  $signed(b[31:0])) ? 1 : 2;
      2'd1: return ($signed(a) == $signed(b)) ? 0 : ($signed(a) < $signed(b)) ? 1 : 2;
      2'd2: return fp_rel({32'd0, a[63:32]}, {32'd0, b[63:32]}, 32, 8);
      default: return fp_rel(a, b, 64, 11);
    endcase
  endfunction

  function automatic logic [3:0] nat_of(int r);
    case (r)
      0: return 4'b0100;
      1: return 4'b1000;
      2: return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] std_of(int r);
    case (r)
      0: return 4'b0110;
      1: return 4'b1000;
      2: return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] k);
    case (k)
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic expect_bits(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sampled at a negedge while the result is held
  task automatic check_result(logic [1:0] k, logic [63:0] a, logic [63:0] b);
    int r;
    r = exp_rel(k, a, b);
    expect_bits("R10", {31'd0, out_valid}, 32'd1);
    case (r)
      0: expect_bits("R1",  {28'd0, out_native}, {28'd0, nat_of(r)});
      1: expect_bits("R2",  {28'd0, out_native}, {28'd0, nat_of(r)});
      2: expect_bits("R3",  {28'd0, out_native}, {28'd0, nat_of(r)});
      default: expect_bits("R4", {28'd0, out_native}, {28'd0, nat_of(r)});
    endcase
    expect_bits(req_of(k), {28'd0, out_native}, {28'd0, nat_of(r)});
    expect_bits("R5", {28'd0, out_std}, {28'd0, std_of(r)});
    expect_bits("R13", {28'd0, out_lt, out_eq, out_gt, out_un},
                {28'd0, r == 1, r == 0, r == 2, r == 3});
  endtask

  task automatic send(logic [1:0] k, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_a = a; in_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(k, a, b);
  endtask

  function automatic logic [63:0] pick(logic [1:0] k, logic [63:0] other);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 8)
      0: v = other;
      1: v = (k == 2'd2) ? {32'h7FC0_0001, v[31:0]} : 64'h7FF0_0000_0000_0001;
      2: v = (k == 2'd2) ? {32'h8000_0000, v[31:0]} : 64'h8000_0000_0000_0000;
      3: v = other ^ 64'h1;
      4: v = other ^ 64'h8000_0000_8000_0000;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    expect_bits("R12", {30'd0, out_valid, in_ready}, 32'b01);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bits("R12", {30'd0, out_valid, in_ready}, 32'b01);

    // directed corners
    send(2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001); // R6 -1 < 1
    send(2'd0, 64'h1234_5678_0000_0005, 64'hABCD_0000_0000_0005); // R6 upper ignored
    send(2'd1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF); // R7
    send(2'd1, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF); // R7
    send(2'd2, 64'h8000_0000_1111_1111, 64'h0000_0000_2222_2222); // R8 -0 == +0
    send(2'd2, 64'h3F80_0000_0000_0000, 64'h4000_0000_FFFF_FFFF); // R8 1 < 2
    send(2'd2, 64'h7FC0_0000_0000_0000, 64'h3F80_0000_0000_0000); // R4 NaN
    send(2'd3, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000); // R9 -2 < -1
    send(2'd3, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000); // R9 zeros
    send(2'd3, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000); // R4 NaN
    send(2'd3, 64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF); // R3 inf > max

    // back-to-back: accept while draining
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd1; in_a = 64'd5; in_b = 64'd9; out_ready = 1'b1;
    @(negedge clk);
    expect_bits("R10", {31'd0, in_ready}, 32'd1);
    check_result(2'd1, 64'd5, 64'd9);
    in_kind = 2'd1; in_a = 64'd9; in_b = 64'd5;
    @(negedge clk);
    check_result(2'd1, 64'd9, 64'd5);
    in_valid = 1'b0;

    // stall with a waiting pair
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd0; in_a = 64'd1; in_b = 64'd1; out_ready = 1'b0;
    @(negedge clk);
    check_result(2'd0, 64'd1, 64'd1);
    in_kind = 2'd0; in_a = 64'd0; in_b = 64'd3;
    @(negedge clk);
    expect_bits("R11", {31'd0, in_ready}, 32'd0);
    check_result(2'd0, 64'd1, 64'd1);
    @(negedge clk);
    expect_bits("R11", {28'd0, out_native}, 32'b0100);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(2'd0, 64'd0, 64'd3);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  k;
      logic [63:0] a, b;
      k = 2'($urandom % 4);
      a = {$urandom, $urandom};
      b = pick(k, a);
      if ($urandom % 2 == 1) begin
        logic [63:0] t;
        t = a; a = b; b = t;
      end
      send(k, a, b);
    end

    @(negedge clk);
    expect_bits("R10", {31'd0, out_valid}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule